// File: doc/BRIEF.md
# Byte-Wide Access Bridge for 16-Bit Registers

This block sits between a master with an 8-bit data path and a bank of three 16-bit registers: one counter/control word and two data words. A 16-bit value moves as two byte accesses, upper byte first. One shared 8-bit holding byte makes each transfer behave as a single 16-bit event. An upper-byte write only parks its byte in the holding byte. The following lower-byte write joins the two halves and loads the whole word on one clock edge. An upper-byte read returns the live upper byte and saves the live lower byte in the holding byte. The following lower-byte read returns that saved byte. The master therefore sees one consistent snapshot, even if the register changes between the two reads.

The counter word can also advance by itself through an enable input, which stands in for the timer logic that uses these registers. All three words are exposed as plain 16-bit outputs. The bus side has no back-pressure. Every strobe is accepted in the cycle it is asserted, the master never waits, and a read returns its data combinationally in that same cycle. The master asserts at most one of the read and write strobes per cycle and always pairs an upper-byte access with a lower-byte access to the same word. Lone byte accesses give undefined results and are not guarded against.

Top module: `bbw_word_bridge`

## Requirements
- R1: An active-low reset clears all three words and the holding byte to zero. A lower-byte read straight after reset returns 0x00.
- R2: A write with `bus_hi`=1 (upper byte) to address 0, 1 or 2 leaves every word unchanged and loads `bus_wdata` into the holding byte.
- R3: A write with `bus_hi`=0 (lower byte) to address 0, 1 or 2 loads that word with {holding byte, `bus_wdata`} at the next clock edge.
- R4: A read with `bus_hi`=1 returns bits 15:8 of the addressed word in the same cycle and copies bits 7:0 of that word into the holding byte at the next edge.
- R5: A read with `bus_hi`=0 returns the holding byte, not the live lower byte of the word, even if the word has changed since the upper-byte read.
- R6: One holding byte serves all three words and both directions. Any upper-byte read or write to address 0 to 2 overwrites it.
- R7: Address 3 is unused. Reads of it return 0x00, and accesses to it change neither the words nor the holding byte.
- R8: Address 0 is the counter word. In each cycle with `count_en`=1 it increments by one, wrapping from 0xFFFF to 0x0000. A lower-byte write to address 0 in the same cycle takes priority over the increment.
- R9: `bus_rdata` is 0x00 in any cycle without `bus_rd`. Strobes in back-to-back cycles are all accepted, with no stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Word select: 0 counter, 1 data A, 2 data B, 3 unused |
| bus_hi | input | 1 | 1 selects the upper byte, 0 the lower byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational |
| count_en | input | 1 | Advances the counter word by one |
| ctl_q | output | 16 | Counter/control word |
| data_a_q | output | 16 | Data word A |
| data_b_q | output | 16 | Data word B |

## Verification
The counter increment can fall in the same cycle as a bus access to the counter word. With a lower-byte write, the write must win. With an upper-byte read, the holding byte must capture the value from before the increment, and the later lower-byte read must still return it while the live word keeps moving. The bench provokes these cases by holding `count_en` high through directed read and write pairs on address 0 and through a long stretch of random accesses. A behavioural model applies the same-cycle priority, and every cycle the bench compares the read byte and all three words against that model.

// File: rtl/bbw_pkg.sv
package bbw_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int NUM_REGS = 3;
  localparam int ADDR_W   = 2;

  typedef logic [ADDR_W-1:0] reg_addr_t;

  localparam reg_addr_t ADDR_CTL = 2'd0;
  localparam reg_addr_t ADDR_DA  = 2'd1;
  localparam reg_addr_t ADDR_DB  = 2'd2;
endpackage

// File: rtl/bbw_hold_byte.sv
module bbw_hold_byte #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/bbw_reg_cell.sv
module bbw_reg_cell #(
  parameter int WORD_W  = 16,
  parameter bit COUNTER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              inc,
  output logic [WORD_W-1:0] q
);
  logic step;

  generate
    if (COUNTER) begin : g_cnt
      assign step = inc;
    end else begin : g_plain
      assign step = 1'b0;
    end
  endgenerate

  // a bus load wins over a count step in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= din;
    else if (step)  q <= q + WORD_W'(1);
  end
endmodule

// File: rtl/bbw_read_mux.sv
module bbw_read_mux #(
  parameter int BYTE_W   = 8,
  parameter int NUM_REGS = 3,
  parameter int ADDR_W   = 2,
  localparam int WORD_W  = 2 * BYTE_W
) (
  input  logic [NUM_REGS-1:0][WORD_W-1:0] regs,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            rd,
  input  logic                            hi,
  input  logic [BYTE_W-1:0]               hold_q,
  output logic                            sel_ok,
  output logic [WORD_W-1:0]               cur_word,
  output logic [BYTE_W-1:0]               rdata
);
  always_comb begin
    sel_ok   = 1'b0;
    cur_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) begin
        sel_ok   = 1'b1;
        cur_word = regs[i];
      end
    end
  end

  always_comb begin
    if (!rd || !sel_ok) rdata = '0;
    else if (hi)        rdata = cur_word[WORD_W-1:BYTE_W];
    else                rdata = hold_q;
  end
endmodule

// File: rtl/bbw_word_bridge.sv
module bbw_word_bridge
  import bbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_hi,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              count_en,
  output logic [WORD_W-1:0] ctl_q,
  output logic [WORD_W-1:0] data_a_q,
  output logic [WORD_W-1:0] data_b_q
);
  logic [NUM_REGS-1:0][WORD_W-1:0] regs;
  logic [WORD_W-1:0] cur_word;
  logic [BYTE_W-1:0] hold_q;
  logic              sel_ok;
  logic              wr_hi, wr_lo, rd_hi;
  logic              hold_load;
  logic [BYTE_W-1:0] hold_din;

  bbw_read_mux #(.BYTE_W(BYTE_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_mux (
    .regs(regs), .addr(bus_addr), .rd(bus_rd), .hi(bus_hi), .hold_q(hold_q),
    .sel_ok(sel_ok), .cur_word(cur_word), .rdata(bus_rdata)
  );

  assign wr_hi = bus_wr && bus_hi && sel_ok;
  assign wr_lo = bus_wr && !bus_hi && sel_ok;
  assign rd_hi = bus_rd && !bus_wr && bus_hi && sel_ok;

  // write byte has priority over a read capture
  assign hold_load = wr_hi || rd_hi;
  assign hold_din  = wr_hi ? bus_wdata : cur_word[BYTE_W-1:0];

  bbw_hold_byte #(.BYTE_W(BYTE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .din(hold_din), .q(hold_q)
  );

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      bbw_reg_cell #(.WORD_W(WORD_W), .COUNTER(i == int'(ADDR_CTL))) u_cell (
        .clk(clk), .rst_n(rst_n),
        .load(wr_lo && (bus_addr == ADDR_W'(i))),
        .din({hold_q, bus_wdata}),
        .inc(count_en),
        .q(regs[i])
      );
    end
  endgenerate

  assign ctl_q    = regs[ADDR_CTL];
  assign data_a_q = regs[ADDR_DA];
  assign data_b_q = regs[ADDR_DB];

  AST_HI_WR_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_hi) |=> ($stable(data_a_q) && $stable(data_b_q))); // R2

  AST_LO_WR_JOINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_hi && bus_addr == ADDR_DA) |=> (data_a_q == {$past(hold_q), $past(bus_wdata)})); // R3

  AST_HI_RD_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_hi && bus_addr == ADDR_DB) |=> $stable(data_b_q)); // R4

  AST_SNAPSHOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_hi && bus_addr == ADDR_DA)
      |=> (!(bus_rd && !bus_wr && !bus_hi && bus_addr != 2'd3) || bus_rdata == $past(data_a_q[BYTE_W-1:0]))); // R5

  AST_SPARE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |=> ($stable(data_a_q) && $stable(data_b_q) && $stable(hold_q))); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !(bus_wr && !bus_hi && bus_addr == ADDR_CTL)) |=> (ctl_q == WORD_W'($past(ctl_q) + 1))); // R8
endmodule

// File: tb/bbw_word_bridge_test.sv
module bbw_word_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_hi = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, count_en = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] ctl_q, data_a_q, data_b_q;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string tag = "R1";

  // behavioural model
  int m_reg [3];
  int m_hold;

  always #5 clk = ~clk;

  bbw_word_bridge uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_hi(bus_hi),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count_en(count_en), .ctl_q(ctl_q), .data_a_q(data_a_q), .data_b_q(data_b_q)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg[0] = 0; m_reg[1] = 0; m_reg[2] = 0; m_hold = 0;
    end else begin
      int a;
      bit lo_ctl;
      a = int'(bus_addr);
      lo_ctl = bus_wr && !bus_hi && a == 0;
      if (a < 3) begin
        if (bus_wr && bus_hi)      m_hold = bus_wdata;
        else if (bus_wr)           m_reg[a] = (m_hold << 8) | bus_wdata;
        else if (bus_rd && bus_hi) m_hold = m_reg[a] & 255;
      end
      if (count_en && !lo_ctl) m_reg[0] = (m_reg[0] + 1) & 16'hFFFF;
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, compare just before the next rising edge
  task automatic step(input bit rd, input bit wr, input bit hi, input int addr,
                      input int wd, input bit cnt, input string t);
    int exp_rd;
    @(negedge clk);
    tag = t;
    bus_rd = rd; bus_wr = wr; bus_hi = hi; bus_addr = 2'(addr);
    bus_wdata = 8'(wd); count_en = cnt;
    #4;
    if (!rd || addr == 3) exp_rd = 0;
    else if (hi)          exp_rd = (m_reg[addr] >> 8) & 255;
    else                  exp_rd = m_hold;
    cmp("rdata", int'(bus_rdata), exp_rd);
    cmp("ctl",   int'(ctl_q),     m_reg[0]);
    cmp("dataA", int'(data_a_q),  m_reg[1]);
    cmp("dataB", int'(data_b_q),  m_reg[2]);
  endtask

  task automatic idle(input string t);
    step(0, 0, 0, 0, 0, 0, t);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, holding byte zero
    step(1, 0, 0, 1, 0, 0, "R1");
    // R2 then R3: word writes
    step(0, 1, 1, 1, 8'h12, 0, "R2");
    step(0, 1, 0, 1, 8'h34, 0, "R3");
    step(0, 1, 1, 2, 8'hAB, 0, "R2");
    step(0, 1, 0, 2, 8'hCD, 0, "R3");
    idle("R3");
    // R4 and R5: snapshot survives a change of the live word
    step(1, 0, 1, 1, 0, 0, "R4");
    step(0, 1, 0, 1, 8'h99, 0, "R5");
    step(1, 0, 0, 1, 0, 0, "R5");
    step(1, 0, 1, 2, 0, 0, "R4");
    step(1, 0, 0, 2, 0, 0, "R5");
    // R8: counter with increment in the same cycles
    step(0, 0, 0, 0, 0, 1, "R8");
    step(1, 0, 1, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 0, 1, "R8");
    step(1, 0, 0, 0, 0, 1, "R8");
    step(0, 1, 1, 0, 8'hFF, 1, "R8");
    step(0, 1, 0, 0, 8'hFF, 1, "R8");
    step(0, 0, 0, 0, 0, 1, "R8");
    idle("R8");
    // R6: shared holding byte
    step(1, 0, 1, 1, 0, 0, "R6");
    step(0, 1, 1, 2, 8'h55, 0, "R6");
    step(1, 0, 0, 1, 0, 0, "R6");
    step(1, 0, 1, 2, 0, 0, "R6");
    step(1, 0, 0, 1, 0, 0, "R6");
    // R7: unused address
    step(1, 0, 1, 1, 0, 0, "R7");
    step(1, 0, 1, 3, 0, 0, "R7");
    step(0, 1, 1, 3, 8'hEE, 0, "R7");
    step(0, 1, 0, 3, 8'h77, 0, "R7");
    step(1, 0, 0, 3, 0, 0, "R7");
    step(1, 0, 0, 1, 0, 0, "R7");
    // R9: quiet bus, back-to-back strobes
    idle("R9");
    step(0, 0, 1, 2, 0, 0, "R9");
    step(0, 1, 1, 1, 8'hC3, 0, "R9");
    step(0, 1, 0, 1, 8'h3C, 0, "R9");
    step(1, 0, 1, 1, 0, 0, "R9");
    step(1, 0, 0, 1, 0, 0, "R9");
    // mixed random traffic, R6 holding-byte sharing under collisions
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 2));
      step(op == 1, op == 2, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), "R6");
    end
    idle("R9");
    finish_run();
  end
endmodule